// File: doc/BRIEF.md
# Predicated Last-Active Element Extractor

This block takes a wide vector operand, a per-byte predicate mask, and a 64-bit scalar. For the element size that a 2-bit code selects, it finds the highest-numbered active element and returns that element, zero-extended, as a scalar result. When no element is active, it returns the low element-width bits of the scalar input, zero-extended.

A mode input chooses which element is taken. In one mode it is the element at the last active index. In the other it is the element just after that index, wrapping to element 0 past the top. The block is a combinational search-and-select path followed by one output register stage. A request is presented with a one-cycle `in_valid` pulse, and the answer appears with `out_valid` one clock later. A flag output reports whether any element was active.

The vector length `VLEN` is a compile-time parameter. It must be a multiple of 128 bits, and its default is 256. Element 0 occupies the least significant bits of `vec`.

Top module: `last_elem_extract`

## Requirements
- R1: The element width is 8 bits shifted left by `size_code` (0→8, 1→16, 2→32, 3→64). The element count is VLEN divided by that width.
- R2: Element e is active when predicate bit `pred[e*W/8]` is set, where W is the element width. Every other predicate bit inside that element's byte group has no effect on the result.
- R3: With `mode_before`=1 and at least one active element, the result is element L zero-extended, where L is the highest active index. Element e is `vec[e*W +: W]`.
- R4: With `mode_before`=0 and at least one active element, the result is element L+1 zero-extended. When L+1 equals the element count, element 0 is used instead.
- R5: With no active element, the result is `scalar_in[W-1:0]` zero-extended to 64 bits.
- R6: For `size_code` below 3 (the 32-bit result case), `result[63:32]` is zero.
- R7: `any_active` is 1 exactly when at least one element was active in the captured request.
- R8: `out_valid` is high for exactly the cycle after each `in_valid` cycle. `result` and `any_active` load only on `in_valid` and hold their value otherwise.
- R9: While `rst_n` is low, `result`, `any_active` and `out_valid` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | Request strobe; captures the computed answer |
| size_code | input | 2 | Element size code (8/16/32/64 bits) |
| mode_before | input | 1 | 1: take the last active element; 0: take the one after it, wrapping |
| pred | input | VLEN/8 | Per-byte predicate mask |
| vec | input | VLEN | Vector operand; element 0 in the low bits |
| scalar_in | input | 64 | Scalar fallback operand |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| result | output | 64 | Zero-extended selected element or fallback |
| any_active | output | 1 | At least one element was active |

## Verification
The assertions assume that `size_code`, `mode_before`, `pred`, `vec` and `scalar_in` are stable and free of X whenever `in_valid` is high. They also assume that reset is applied before the first request. The bench changes inputs only on falling clock edges and drives every field to a defined value, including on idle cycles where it loads deliberate junk to show that the outputs hold. Random predicates are thinned so that empty, single-element and top-element cases all occur. Directed cases cover the wrap from the last element and masks whose only set bits are non-leading bytes.

// File: rtl/lx_pkg.sv
package lx_pkg;

  // Element size codes; the numeric value is the shift applied to 8 bits.
  typedef enum logic [1:0] {
    ESZ_8  = 2'd0,
    ESZ_16 = 2'd1,
    ESZ_32 = 2'd2,
    ESZ_64 = 2'd3
  } esz_e;

  localparam int unsigned NUM_SIZES = 4;
  localparam int unsigned RES_W     = 64;

  // Mask of the low element-width bits for a size code.
  function automatic logic [RES_W-1:0] width_mask(input logic [1:0] sz);
    logic [RES_W-1:0] m;
    case (sz)
      ESZ_8:   m = 64'h0000_0000_0000_00FF;
      ESZ_16:  m = 64'h0000_0000_0000_FFFF;
      ESZ_32:  m = 64'h0000_0000_FFFF_FFFF;
      default: m = 64'hFFFF_FFFF_FFFF_FFFF;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/lx_scan.sv
// Priority search for the highest active element, one lane per element size.
module lx_scan #(
  parameter int unsigned VLEN = 256,
  localparam int unsigned NB  = VLEN / 8,
  localparam int unsigned IW  = $clog2(NB) + 1
) (
  input  logic [NB-1:0] pred,
  input  logic [1:0]    size_code,
  output logic          found,
  output logic [IW-1:0] last_idx
);

  for (genvar s = 0; s < 4; s++) begin : g_sz
    localparam int unsigned STEP = 1 << s;
    localparam int unsigned NE   = NB / STEP;
    logic          hit;
    logic [IW-1:0] idx;

    // Only the leading byte bit of each element group is examined.
    always_comb begin
      hit = 1'b0;
      idx = '0;
      for (int e = 0; e < NE; e++) begin
        if (pred[e*STEP]) begin
          hit = 1'b1;
          idx = IW'(e);
        end
      end
    end
  end

  always_comb begin
    case (size_code)
      2'd0:    begin found = g_sz[0].hit; last_idx = g_sz[0].idx; end
      2'd1:    begin found = g_sz[1].hit; last_idx = g_sz[1].idx; end
      2'd2:    begin found = g_sz[2].hit; last_idx = g_sz[2].idx; end
      default: begin found = g_sz[3].hit; last_idx = g_sz[3].idx; end
    endcase
  end

endmodule

// File: rtl/lx_pick.sv
// Index adjustment (optional wrapping increment) and element selection.
module lx_pick #(
  parameter int unsigned VLEN = 256,
  localparam int unsigned NB  = VLEN / 8,
  localparam int unsigned IW  = $clog2(NB) + 1
) (
  input  logic [VLEN-1:0] vec,
  input  logic [1:0]      size_code,
  input  logic            mode_before,
  input  logic [IW-1:0]   last_idx,
  output logic [IW-1:0]   sel_idx,
  output logic [63:0]     elem
);

  logic [IW-1:0] count;
  logic [IW-1:0] inc_idx;

  always_comb begin
    count   = IW'(NB) >> size_code;
    inc_idx = last_idx + 1'b1;
    if (mode_before)          sel_idx = last_idx;
    else if (inc_idx == count) sel_idx = '0;
    else                       sel_idx = inc_idx;
  end

  for (genvar s = 0; s < 4; s++) begin : g_sel
    localparam int unsigned ESZ = 8 << s;
    localparam int unsigned NE  = VLEN / ESZ;
    localparam int unsigned LW  = $clog2(NE);
    logic [LW-1:0]  loc;
    logic [ESZ-1:0] part;
    logic [63:0]    wide;

    always_comb begin
      loc  = sel_idx[LW-1:0];
      part = vec[int'(loc)*ESZ +: ESZ];
      wide = 64'(part);
    end
  end

  always_comb begin
    case (size_code)
      2'd0:    elem = g_sel[0].wide;
      2'd1:    elem = g_sel[1].wide;
      2'd2:    elem = g_sel[2].wide;
      default: elem = g_sel[3].wide;
    endcase
  end

endmodule

// File: rtl/lx_merge.sv
// Chooses between the selected element and the truncated scalar fallback.
module lx_merge (
  input  logic        found,
  input  logic [1:0]  size_code,
  input  logic [63:0] elem,
  input  logic [63:0] scalar_in,
  output logic [63:0] merged
);
  import lx_pkg::*;

  always_comb begin
    if (found) merged = elem;
    else       merged = scalar_in & width_mask(size_code);
  end

endmodule

// File: rtl/last_elem_extract.sv
module last_elem_extract #(
  parameter int unsigned VLEN = 256,
  localparam int unsigned NB  = VLEN / 8,
  localparam int unsigned IW  = $clog2(NB) + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [1:0]      size_code,
  input  logic            mode_before,
  input  logic [NB-1:0]   pred,
  input  logic [VLEN-1:0] vec,
  input  logic [63:0]     scalar_in,
  output logic            out_valid,
  output logic [63:0]     result,
  output logic            any_active
);

  logic          scan_found;
  logic [IW-1:0] scan_idx;
  logic [IW-1:0] sel_idx;
  logic [63:0]   elem;
  logic [63:0]   merged;

  lx_scan #(.VLEN(VLEN)) u_scan (
    .pred      (pred),
    .size_code (size_code),
    .found     (scan_found),
    .last_idx  (scan_idx)
  );

  lx_pick #(.VLEN(VLEN)) u_pick (
    .vec         (vec),
    .size_code   (size_code),
    .mode_before (mode_before),
    .last_idx    (scan_idx),
    .sel_idx     (sel_idx),
    .elem        (elem)
  );

  lx_merge u_merge (
    .found     (scan_found),
    .size_code (size_code),
    .elem      (elem),
    .scalar_in (scalar_in),
    .merged    (merged)
  );

  // Next-state logic with explicit load enable.
  logic        valid_d;
  logic [63:0] result_d;
  logic        active_d;

  always_comb begin
    valid_d  = in_valid;
    result_d = result;
    active_d = any_active;
    if (in_valid) begin
      result_d = merged;
      active_d = scan_found;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      result     <= '0;
      any_active <= 1'b0;
    end else begin
      out_valid  <= valid_d;
      result     <= result_d;
      any_active <= active_d;
    end
  end

  // ---------------- assertions ----------------
  logic [IW+2:0] lead_byte;
  logic [IW-1:0] elem_count;
  always_comb begin
    lead_byte  = {3'b000, scan_idx} << size_code;
    elem_count = IW'(NB) >> size_code;
  end

  assert_scan_hit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && scan_found) |-> pred[lead_byte]);

  assert_idx_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && scan_found) |-> (sel_idx < elem_count));

  assert_empty_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && pred == '0) |=> !any_active);

  assert_upper_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && size_code != 2'd3) |=> (result[63:32] == 32'd0));

  assert_valid_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_valid_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(result) && $stable(any_active)));

endmodule

// File: tb/sim_last_elem_extract.sv
`timescale 1ns/1ps
module sim_last_elem_extract;
  localparam int unsigned VLEN = 256;
  localparam int unsigned NB   = VLEN / 8;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            in_valid;
  logic [1:0]      size_code;
  logic            mode_before;
  logic [NB-1:0]   pred;
  logic [VLEN-1:0] vec;
  logic [63:0]     scalar_in;
  logic            out_valid;
  logic [63:0]     result;
  logic            any_active;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  last_elem_extract #(.VLEN(VLEN)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .size_code(size_code),
    .mode_before(mode_before), .pred(pred), .vec(vec), .scalar_in(scalar_in),
    .out_valid(out_valid), .result(result), .any_active(any_active)
  );

  function automatic logic [63:0] msk(input int w);
    return (w == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << w) - 64'd1);
  endfunction

  // Reference model: returns {any, value}.
  function automatic logic [64:0] model(input logic [1:0] sz, input logic bef,
      input logic [NB-1:0] p, input logic [VLEN-1:0] v, input logic [63:0] sc);
    int w = 8 << sz;
    int n = VLEN / w;
    int last = -1;
    int idx;
    for (int e = 0; e < n; e++) if (p[e*(w/8)]) last = e;
    if (last < 0) return {1'b0, sc & msk(w)};
    idx = bef ? last : ((last + 1 == n) ? 0 : last + 1);
    return {1'b1, 64'(v >> (idx*w)) & msk(w)};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [VLEN-1:0] rnd_vec();
    logic [VLEN-1:0] v;
    for (int i = 0; i < VLEN/32; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  // One request; checks the registered answer one cycle later, then
  // idles with junk inputs and checks that the outputs hold.
  task automatic run(input logic [1:0] sz, input logic bef, input logic [NB-1:0] p,
                     input logic [VLEN-1:0] v, input logic [63:0] sc, input string tag);
    logic [64:0] exp;
    exp = model(sz, bef, p, v, sc);
    @(negedge clk);
    in_valid = 1'b1; size_code = sz; mode_before = bef;
    pred = p; vec = v; scalar_in = sc;
    @(negedge clk);
    in_valid = 1'b0;
    pred = ~p; vec = ~v; scalar_in = ~sc; mode_before = ~bef;
    chk(out_valid == 1'b1, "R8 out_valid", 64'(out_valid), 64'd1);
    chk(result == exp[63:0], tag, result, exp[63:0]);
    chk(any_active == exp[64], "R7 any_active", 64'(any_active), 64'(exp[64]));
    if (sz != 2'd3) chk(result[63:32] == 32'd0, "R6 upper", result, exp[63:0]);
    @(negedge clk);
    chk(out_valid == 1'b0, "R8 pulse", 64'(out_valid), 64'd0);
    chk(result == exp[63:0], "R8 hold", result, exp[63:0]);
  endtask

  initial begin : watchdog
    int cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [NB-1:0] p;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; in_valid = 1'b0; size_code = '0; mode_before = 1'b0;
    pred = '1; vec = '1; scalar_in = '1;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0 && result == 64'd0 && any_active == 1'b0,
        "R9 reset", result, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // Directed corners, every size and both modes.
    for (int s = 0; s < 4; s++) begin
      int w = 8 << s;
      int n = VLEN / w;
      for (int b = 0; b < 2; b++) begin
        run(2'(s), 1'(b), '0, rnd_vec(), {$urandom, $urandom}, "R5 fallback");
        p = '0; p[(n-1)*(w/8)] = 1'b1;
        run(2'(s), 1'(b), p, rnd_vec(), {$urandom, $urandom},
            b ? "R3 top element" : "R4 wrap to 0");
        p = '0; p[0] = 1'b1;
        run(2'(s), 1'(b), p, rnd_vec(), {$urandom, $urandom},
            b ? "R3 element 0" : "R4 element 1");
        if (w > 8) begin
          p = '0;
          for (int e = 0; e < n; e++) p[e*(w/8) + 1] = 1'b1;
          run(2'(s), 1'(b), p, rnd_vec(), {$urandom, $urandom}, "R2 non-lead ignored");
        end
      end
    end
    // R1: same operands under each size code give different widths.
    for (int s = 0; s < 4; s++)
      run(2'(s), 1'b1, '1, '1, 64'd0, "R1 width");

    // Constrained random.
    for (int i = 0; i < 400; i++) begin
      p = '0;
      case ($urandom % 4)
        0: p = '0;
        1: p[$urandom % NB] = 1'b1;
        2: for (int k = 0; k < NB/32; k++) p[k*32 +: 32] = $urandom & $urandom & $urandom;
        default: for (int k = 0; k < NB/32; k++) p[k*32 +: 32] = $urandom;
      endcase
      run(2'($urandom), 1'($urandom), p, rnd_vec(), {$urandom, $urandom},
          "R3/R4/R5 random");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule